// File: doc/BRIEF.md
# Wiper Stepping Host Sequencer

This block is the host-side master for one digitally adjustable resistor channel that is controlled over a three-wire interface. The three wires are an active-low select, a direction level and an increment strobe. A client issues one command, made of a signed step count and a save flag. The sequencer then selects the device, sets the direction and emits one increment pulse per step. It releases the select with the increment line at the level that either commits the new wiper position to non-volatile storage or discards it. Before it goes idle, it waits out the deselect recovery time.

Every setup, pulse-width and recovery interval is a parameter counted in clock cycles, so the same block serves any clock rate. The block also keeps a model of where the wiper should now be. The device stops at both end taps and never wraps, so this model is clamped to the same range. A client reads `busy` and `done` to pace its commands and reads `pos` to learn the expected tap.

Top module: `wstep_seq`

## Requirements
- R1: During and directly after reset: `cs_n`=1, `inc`=1, `ud`=1, `busy`=0, `done`=0 and `pos`=INIT_POS.
- R2: A command is taken only when `cmd_valid` is sampled high while the block is idle. `cmd_valid` pulses during a sequence have no effect on any output.
- R3: In the cycle after an accepted command, `cs_n` falls with `inc` high. `cs_n` stays low with `inc` high for T_CS cycles before the direction phase starts.
- R4: After the direction phase, each step drives `inc` high for T_HI cycles and then low for T_LO cycles. The number of falling edges on `inc` equals the magnitude of the step count.
- R5: `pos` moves by one in the cycle in which `inc` falls: up when `ud`=1, down when `ud`=0. It holds at 0 and at 2^POS_W-1 and never wraps.
- R6: With save set, `inc` is high for the T_IC-cycle release phase. `cs_n` then rises with `inc` high, and the block stays busy for T_ST further cycles.
- R7: With save clear, `inc` stays low for the T_IC-cycle release phase. `cs_n` rises with `inc` low, the block waits T_CPH cycles, and `inc` returns high when idle.
- R8: `busy` is high from the cycle after acceptance to the end of the deselect wait. `done` is high for exactly the first idle cycle after a sequence.
- R9: A zero step count with save set runs the select, release and store-wait phases with no falling edge on `inc`.
- R10: A zero step count with save clear touches no interface line. `done` pulses in the cycle after acceptance, and `busy` stays low.
- R11: `ud` changes only at the start of the T_DI-cycle direction phase, while `cs_n` is low. Its value is 1 for a step count of zero or more and 0 for a negative one. It is stable at every falling edge of `inc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_steps | input | STEP_W | Signed step count, two's complement |
| cmd_save | input | 1 | 1: commit position at release, 0: discard |
| cs_n | output | 1 | Active-low device select |
| ud | output | 1 | Direction level, 1 = up |
| inc | output | 1 | Increment strobe, steps on falling edge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| pos | output | POS_W | Expected wiper tap |

## Verification
The hardest case to reach is a command arriving in the very cycle that `done` is high. In that cycle the block must accept the new command, start a second select and reverse the direction without any stray increment edge. The stimulus reaches it by issuing a reversing command as soon as `done` is seen, so that acceptance lands on the done cycle. Clamping at both end taps is reached with step counts larger than the remaining range. A separate run pulses `cmd_valid` with a different count in mid-sequence to show that the pulse is ignored.

// File: rtl/wstep_pkg.sv
`timescale 1ns/1ps
package wstep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_DIR,
    ST_HI,
    ST_LO,
    ST_REL,
    ST_DESEL
  } wstep_state_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wstep_timer.sv
`timescale 1ns/1ps
module wstep_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/wstep_pos.sv
`timescale 1ns/1ps
module wstep_pos #(
  parameter int unsigned POS_W    = 5,
  parameter int unsigned INIT_POS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             up,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] TOP_TAP  = '1;
  localparam logic [POS_W-1:0] INIT_TAP = POS_W'(INIT_POS);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= INIT_TAP;
    end else if (step) begin
      if (up && pos != TOP_TAP)     pos <= pos + 1'b1;
      else if (!up && pos != '0)    pos <= pos - 1'b1;
    end
  end
endmodule

// File: rtl/wstep_seq.sv
`timescale 1ns/1ps
module wstep_seq
  import wstep_pkg::*;
#(
  parameter int unsigned POS_W    = 5,
  parameter int unsigned INIT_POS = 16,
  parameter int unsigned STEP_W   = 6,
  parameter int unsigned T_CS     = 25,
  parameter int unsigned T_DI     = 25,
  parameter int unsigned T_HI     = 250,
  parameter int unsigned T_LO     = 250,
  parameter int unsigned T_IC     = 250,
  parameter int unsigned T_ST     = 2500000,
  parameter int unsigned T_CPH    = 63
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmd_valid,
  input  logic signed [STEP_W-1:0] cmd_steps,
  input  logic                     cmd_save,
  output logic                     cs_n,
  output logic                     ud,
  output logic                     inc,
  output logic                     busy,
  output logic                     done,
  output logic [POS_W-1:0]         pos
);
  localparam int unsigned T_MAX = umax(umax(umax(T_CS, T_DI), umax(T_HI, T_LO)),
                                       umax(umax(T_IC, T_ST), T_CPH));
  localparam int unsigned CNT_W = $clog2(T_MAX + 1);

  wstep_state_e      state, nxt;
  logic [STEP_W-1:0] rem_q;
  logic [STEP_W-1:0] cmd_mag;
  logic              save_q, dir_q;
  logic              noop, accept;
  logic              ld, step_en, tmr_zero;
  logic [CNT_W-1:0]  ldv;

  assign cmd_mag = cmd_steps[STEP_W-1] ? (~cmd_steps + 1'b1) : cmd_steps;
  assign noop    = (cmd_mag == '0) && !cmd_save;
  assign accept  = (state == ST_IDLE) && cmd_valid && !noop;

  always_comb begin
    nxt     = state;
    ld      = 1'b0;
    ldv     = '0;
    step_en = 1'b0;
    case (state)
      ST_IDLE: if (accept) begin
        nxt = ST_SEL; ld = 1'b1; ldv = CNT_W'(T_CS - 1);
      end
      ST_SEL: if (tmr_zero) begin
        nxt = ST_DIR; ld = 1'b1; ldv = CNT_W'(T_DI - 1);
      end
      ST_DIR, ST_LO: if (tmr_zero) begin
        ld = 1'b1;
        if (rem_q != '0) begin nxt = ST_HI;  ldv = CNT_W'(T_HI - 1); end
        else             begin nxt = ST_REL; ldv = CNT_W'(T_IC - 1); end
      end
      ST_HI: if (tmr_zero) begin
        nxt = ST_LO; ld = 1'b1; ldv = CNT_W'(T_LO - 1); step_en = 1'b1;
      end
      ST_REL: if (tmr_zero) begin
        nxt = ST_DESEL; ld = 1'b1;
        ldv = save_q ? CNT_W'(T_ST - 1) : CNT_W'(T_CPH - 1);
      end
      ST_DESEL: if (tmr_zero) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      rem_q  <= '0;
      save_q <= 1'b0;
      dir_q  <= 1'b1;
      cs_n   <= 1'b1;
      inc    <= 1'b1;
      ud     <= 1'b1;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      state <= nxt;
      if (accept) begin
        rem_q  <= cmd_mag;
        save_q <= cmd_save;
        dir_q  <= ~cmd_steps[STEP_W-1];
      end else if (step_en) begin
        rem_q <= rem_q - 1'b1;
      end
      cs_n <= (nxt == ST_IDLE) || (nxt == ST_DESEL);
      case (nxt)
        ST_LO:           inc <= 1'b0;
        ST_REL, ST_DESEL: inc <= save_q;
        default:         inc <= 1'b1;
      endcase
      if (nxt == ST_DIR && state != ST_DIR) ud <= dir_q;
      busy <= (nxt != ST_IDLE);
      done <= ((state != ST_IDLE) && (nxt == ST_IDLE)) ||
              ((state == ST_IDLE) && cmd_valid && noop);
    end
  end

  wstep_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(ld), .load_val(ldv), .expired(tmr_zero)
  );

  wstep_pos #(.POS_W(POS_W), .INIT_POS(INIT_POS)) u_pos (
    .clk(clk), .rst(rst), .step(step_en), .up(dir_q), .pos(pos)
  );
endmodule

// File: rtl/wstep_chk.sv
`timescale 1ns/1ps
module wstep_chk #(
  parameter int unsigned POS_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n,
  input logic             ud,
  input logic             inc,
  input logic             busy,
  input logic             done,
  input logic [POS_W-1:0] pos
);
  AST_FALL_ONLY_SELECTED: assert property (@(posedge clk) disable iff (rst)
    $fell(inc) |-> (!cs_n && $past(!cs_n)));  // R4
  AST_UD_HELD_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(inc) |-> $stable(ud));  // R11
  AST_UD_CHANGE_SELECTED: assert property (@(posedge clk) disable iff (rst)
    !$stable(ud) |-> (!cs_n && $past(!cs_n) && inc));  // R11
  AST_POS_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(pos) |-> $fell(inc));  // R5
  AST_POS_UNIT_MOVE: assert property (@(posedge clk) disable iff (rst)
    !$stable(pos) |-> (({1'b0, pos} == {1'b0, $past(pos)} + 1'b1) ||
                       ({1'b0, $past(pos)} == {1'b0, pos} + 1'b1)));  // R5
  AST_CS_RISE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> ($stable(inc) && busy));  // R6
  AST_CS_FALL_INC_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (inc && busy));  // R3
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && cs_n && inc));  // R8
endmodule

bind wstep_seq wstep_chk #(.POS_W(POS_W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .ud(ud), .inc(inc),
  .busy(busy), .done(done), .pos(pos)
);

// File: tb/sim_wstep_seq.sv
`timescale 1ns/1ps
module sim_wstep_seq;
  localparam int T_CS = 2, T_DI = 3, T_HI = 4, T_LO = 3, T_IC = 5, T_ST = 40, T_CPH = 2;
  localparam int INIT = 16;

  typedef struct packed {
    logic       cs_n;
    logic       inc;
    logic       ud;
    logic       busy;
    logic       done;
    logic [4:0] pos;
  } ev_t;

  logic clk = 1'b0, rst = 1'b1, cmd_valid = 1'b0, cmd_save = 1'b0;
  logic signed [6:0] cmd_steps = '0;
  logic cs_n, ud, inc, busy, done;
  logic [4:0] pos;

  int checks = 0, errors = 0, falls = 0, cycles = 0;
  logic prev_inc = 1'b1;
  string cur_req = "R1";
  ev_t q[$];
  ev_t cur;

  always #2 clk = ~clk;

  wstep_seq #(.POS_W(5), .INIT_POS(INIT), .STEP_W(7), .T_CS(T_CS), .T_DI(T_DI),
              .T_HI(T_HI), .T_LO(T_LO), .T_IC(T_IC), .T_ST(T_ST), .T_CPH(T_CPH)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_steps(cmd_steps), .cmd_save(cmd_save),
    .cs_n(cs_n), .ud(ud), .inc(inc), .busy(busy), .done(done), .pos(pos));

  function automatic void push_n(int n, ev_t v);
    for (int i = 0; i < n; i++) q.push_back(v);
  endfunction

  // Reference model: builds the whole expected waveform when a command is taken
  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      cur = '{cs_n:1'b1, inc:1'b1, ud:1'b1, busy:1'b0, done:1'b0, pos:5'(INIT)};
    end else begin
      if (!cur.busy && cmd_valid) begin
        int s, mag;
        logic up, sv;
        ev_t v;
        s = int'(cmd_steps);
        mag = (s < 0) ? -s : s;
        up = (s >= 0);
        sv = cmd_save;
        v = cur;
        v.done = 1'b0;
        if (mag == 0 && !sv) begin
          v.done = 1'b1; v.busy = 1'b0; v.cs_n = 1'b1; v.inc = 1'b1;
          q.push_back(v);
        end else begin
          v.cs_n = 1'b0; v.inc = 1'b1; v.busy = 1'b1;
          push_n(T_CS, v);
          v.ud = up;
          push_n(T_DI, v);
          for (int k = 0; k < mag; k++) begin
            v.inc = 1'b1; push_n(T_HI, v);
            if (up) v.pos = (v.pos == 5'd31) ? v.pos : v.pos + 5'd1;
            else    v.pos = (v.pos == 5'd0)  ? v.pos : v.pos - 5'd1;
            v.inc = 1'b0; push_n(T_LO, v);
          end
          v.inc = sv; push_n(T_IC, v);
          v.cs_n = 1'b1; push_n(sv ? T_ST : T_CPH, v);
          v.inc = 1'b1; v.busy = 1'b0; v.done = 1'b1;
          q.push_back(v);
        end
      end
      if (q.size() > 0) cur = q.pop_front();
      else begin
        cur.done = 1'b0; cur.busy = 1'b0; cur.cs_n = 1'b1; cur.inc = 1'b1;
      end
    end
  end

  // Cycle compare and edge counting, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      ev_t act;
      act = '{cs_n:cs_n, inc:inc, ud:ud, busy:busy, done:done, pos:pos};
      checks++;
      if (act !== cur) begin
        errors++;
        $display("FAIL %s (R3 R8 waveform) actual cs_n=%b inc=%b ud=%b busy=%b done=%b pos=%0d expected cs_n=%b inc=%b ud=%b busy=%b done=%b pos=%0d",
                 cur_req, cs_n, inc, ud, busy, done, pos,
                 cur.cs_n, cur.inc, cur.ud, cur.busy, cur.done, cur.pos);
      end
      if (prev_inc && !inc) falls++;
    end
    prev_inc = inc;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int steps, input logic sv);
    cmd_steps = 7'(steps); cmd_save = sv; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic run(input string req, input int steps, input logic sv, input int exp_pos);
    cur_req = req; falls = 0;
    send(steps, sv);
    wait_done();
    check({req, " R4 falls"}, falls, (steps < 0) ? -steps : steps);
    check({req, " R5 pos"}, int'(pos), exp_pos);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 cs_n", int'(cs_n), 1);
    check("R1 inc", int'(inc), 1);
    check("R1 ud", int'(ud), 1);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 pos", int'(pos), INIT);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R7 no-save up steps; R3 R8 select and busy right after accept
    cur_req = "R7"; falls = 0;
    send(3, 1'b0);
    check("R3 cs_n low after accept", int'(cs_n), 0);
    check("R8 busy after accept", int'(busy), 1);
    wait_done();
    check("R7 R4 falls", falls, 3);
    check("R7 R5 pos", int'(pos), 19);
    @(negedge clk);

    run("R6", -5, 1'b1, 14);
    @(negedge clk);
    run("R5 clamp high", 20, 1'b0, 31);
    run("R5 clamp low", -40, 1'b1, 0);
    run("R9", 0, 1'b1, 0);
    run("R10", 0, 1'b0, 0);
    check("R10 busy stays low", int'(busy), 0);

    // R11 reversal accepted in the done cycle
    run("R11 up", 2, 1'b0, 2);
    run("R11 down", -2, 1'b0, 0);

    // R2 mid-sequence command is ignored
    cur_req = "R2"; falls = 0;
    send(4, 1'b0);
    repeat (6) @(negedge clk);
    cmd_steps = -7'sd7; cmd_save = 1'b1; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done();
    check("R2 falls", falls, 4);
    check("R2 pos", int'(pos), 4);
    repeat (4) @(negedge clk);
    check("R2 stays idle", int'(busy), 0);
    finish_run();
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual %0d cycles expected completion", cycles);
    finish_run();
  end
endmodule